// File: doc/BRIEF.md
# Serial Character Transmitter with Selectable Parity

This block turns characters into asynchronous serial frames on a single line that rests high. Characters are written into a small holding FIFO. An external bit-rate strobe paces the frames. Each frame has a low start bit, the data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. The frame format is taken from static configuration inputs when a character leaves the FIFO.

A three-bit parity selector chooses one of five parity options:

- no parity bit;
- odd parity;
- even parity;
- a parity bit fixed at one;
- a parity bit fixed at zero.

In nine-bit mode the parity selector is ignored and the ninth data bit is sent where the parity bit would be. A break input holds the line low without disturbing the frame sequencer. Two flags give transmit progress: one shows that the holding FIFO is empty, and the other shows that the whole transmitter is idle.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd` is 1, `fifo_empty` is 1 and `tx_idle` is 1.
- R2: A frame starts with one 0 start bit, followed by the data bits from `wr_data[0]` upward. With `nine_bit`=0 the data width is 5 + `word_len`: 00→5, 01→6, 10→7, 11→8. Each bit lasts exactly one strobe period.
- R3: When `par_sel[0]` is 0, no parity bit is sent, and the first stop bit follows the last data bit directly.
- R4: `par_sel`=001 adds a parity bit that makes the count of ones in data plus parity odd. `par_sel`=011 makes that count even.
- R5: `par_sel`=101 sends a parity bit of 1, and `par_sel`=111 sends a parity bit of 0.
- R6: With `nine_bit`=1, nine data bits are sent (`wr_data[8]` last). No parity bit is sent, and both `word_len` and `par_sel` have no effect.
- R7: `two_stop`=0 sends one high stop bit, and `two_stop`=1 sends two.
- R8: While `brk` is 1, `txd` is 0, including while idle. A frame in progress keeps its timing, so its remaining bits appear on schedule once `brk` returns to 0.
- R9: `fifo_empty` is 1 exactly when the holding FIFO holds no character. It falls after a write and rises on the strobe that takes the last character.
- R10: `tx_idle` is 1 only when the FIFO is empty and the shifter has finished the last stop bit. It rises on the strobe edge that ends the final stop bit.
- R11: The first frame starts on the next strobe after a character is written to an idle transmitter. Queued characters follow one another with no idle gap between the last stop bit and the next start bit.
- R12: A write while the FIFO already holds FIFO_DEPTH (default 4) characters is dropped, and that character is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-rate strobe |
| wr_en | input | 1 | Write a character into the holding FIFO |
| wr_data | input | 9 | Character, LSB first on the line |
| word_len | input | 2 | Data width select, 5 + value bits |
| two_stop | input | 1 | 1 selects two stop bits |
| par_sel | input | 3 | Parity selector |
| nine_bit | input | 1 | Nine data bits, no parity |
| brk | input | 1 | Force line low |
| txd | output | 1 | Serial line |
| fifo_empty | output | 1 | Holding FIFO empty |
| tx_idle | output | 1 | FIFO and shifter both empty |

## Verification
Three kinds of internal fault show up on `txd`:

- A wrong bit counter lengthens or shortens a frame.
- A wrong shift register misplaces a data bit.
- A wrong parity or framing decode gives a wrong bit in a position that the format fixes.

Each of these is visible within a single frame, at the strobe where that bit is sampled. A stuck busy state or a bad FIFO count shows up at `tx_idle` one clock after the final stop period. It also shows as a missing or extra start bit on the following strobe. The sweep covers every word length, parity code, stop count and framing mode, so every bit position of every format is compared against arithmetic expectations.

// File: rtl/sertx_pkg.sv
// Shared types and sizes for the serial transmitter.
// Assumes at most nine data bits, one parity bit and two stop bits per frame.
package sertx_pkg;
    localparam int MAX_DATA  = 9;
    localparam int FRAME_W   = 1 + MAX_DATA + 1 + 2;
    localparam int LEN_W     = $clog2(FRAME_W + 1);

    // Parity kind, taken from the upper two bits of the selector
    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_kind_e;

    // Assembled frame: line bits in send order (bit 0 first) and bit count
    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;
endpackage

// File: rtl/sertx_fifo.sv
// Holding FIFO for characters waiting to be sent.
// Writes while full are dropped. A pop is only issued while not empty.
module sertx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] rd_data,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic          full, do_wr, do_rd;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign do_wr = wr_en && !full;
    assign do_rd = pop && !empty;
    assign rd_data = mem[rp];

    // Store an accepted character
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_wr) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sertx_framer.sv
// Builds the line bit sequence of one frame from a character and the format.
// Purely combinational. The frame is padded with ones beyond its length.
module sertx_framer
    import sertx_pkg::*;
(
    input  logic [MAX_DATA-1:0] data,
    input  logic [1:0]          word_len,
    input  logic                two_stop,
    input  logic [2:0]          par_sel,
    input  logic                nine_bit,
    output frame_t              frm
);
    // Assemble start, data, optional parity and stop bits
    always_comb begin
        int        nd;
        logic      acc;
        logic      pbit;
        logic      par_on;
        par_kind_e kind;

        nd     = nine_bit ? MAX_DATA : 5 + int'(word_len);
        par_on = !nine_bit && par_sel[0];
        acc    = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < nd) acc = acc ^ data[i];
        end
        kind = par_kind_e'(par_sel[2:1]);
        case (kind)
            PAR_ODD:   pbit = ~acc;
            PAR_EVEN:  pbit = acc;
            PAR_MARK:  pbit = 1'b1;
            default:   pbit = 1'b0;
        endcase

        frm.bits    = '1;
        frm.bits[0] = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < nd) frm.bits[i + 1] = data[i];
        end
        if (par_on) frm.bits[nd + 1] = pbit;
        frm.len = LEN_W'(1 + nd + (par_on ? 1 : 0) + (two_stop ? 2 : 1));
    end
endmodule

// File: rtl/sertx_shifter.sv
// Frame sequencer: loads a frame on a strobe and shifts one bit per strobe.
// Assumes the frame length is at least 7. A new frame may load on the strobe
// that ends the last stop bit, so queued frames run back to back.
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bit_tick,
    input  logic   avail,
    input  frame_t frm,
    output logic   pop,
    output logic   line,
    output logic   busy
);
    logic [FRAME_W-1:0] sr;
    logic [LEN_W-1:0]   cnt;
    logic               last;

    assign last = busy && (cnt == LEN_W'(1));
    assign pop  = bit_tick && avail && (!busy || last);

    // Load, shift and retire frames on bit strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            line <= 1'b1;
            cnt  <= '0;
            sr   <= '1;
        end else if (bit_tick) begin
            if (pop) begin
                busy <= 1'b1;
                line <= frm.bits[0];
                sr   <= {1'b1, frm.bits[FRAME_W-1:1]};
                cnt  <= frm.len;
            end else if (last) begin
                busy <= 1'b0;
                line <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                line <= sr[0];
                sr   <= {1'b1, sr[FRAME_W-1:1]};
                cnt  <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sertx_top.sv
// Serial transmitter: holding FIFO, framer and sequencer, plus the break override.
// Format inputs are sampled when a character leaves the FIFO. Break only gates the line.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       wr_en,
    input  logic [8:0] wr_data,
    input  logic [1:0] word_len,
    input  logic       two_stop,
    input  logic [2:0] par_sel,
    input  logic       nine_bit,
    input  logic       brk,
    output logic       txd,
    output logic       fifo_empty,
    output logic       tx_idle
);
    logic [MAX_DATA-1:0] head;
    logic                fifo_pop;
    logic                sh_line;
    logic                sh_busy;
    frame_t              frame;

    sertx_fifo #(.DEPTH(FIFO_DEPTH), .W(MAX_DATA)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (fifo_pop),
        .rd_data (head),
        .empty   (fifo_empty)
    );

    sertx_framer u_framer (
        .data     (head),
        .word_len (word_len),
        .two_stop (two_stop),
        .par_sel  (par_sel),
        .nine_bit (nine_bit),
        .frm      (frame)
    );

    sertx_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .avail    (!fifo_empty),
        .frm      (frame),
        .pop      (fifo_pop),
        .line     (sh_line),
        .busy     (sh_busy)
    );

    // Line output with break override; idle means nothing queued or shifting
    assign txd     = brk ? 1'b0 : sh_line;
    assign tx_idle = fifo_empty && !sh_busy;
endmodule

// File: rtl/sertx_chk.sv
// Temporal checks on the serial transmitter, bound into sertx_top.
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic brk,
    input logic txd,
    input logic fifo_empty,
    input logic tx_idle,
    input logic busy,
    input logic line,
    input logic pop
);
    // R10
    idle_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> fifo_empty);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && !brk) |-> txd);

    // R11
    pop_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> bit_tick);

    // R2
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (!line && busy));

    // R2
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(line));

    // R10
    idle_rise_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_idle) |-> $past(bit_tick));
endmodule

bind sertx_top sertx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .brk        (brk),
    .txd        (txd),
    .fifo_empty (fifo_empty),
    .tx_idle    (tx_idle),
    .busy       (sh_busy),
    .line       (sh_line),
    .pop        (fifo_pop)
);

// File: tb/sertx_top_test.sv
// Sweeps every frame format and compares each line bit with an arithmetic model.
module sertx_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [1:0] word_len = '0;
    logic       two_stop = 1'b0;
    logic [2:0] par_sel = '0;
    logic       nine_bit = 1'b0;
    logic       brk = 1'b0;
    logic       txd, fifo_empty, tx_idle;
    logic       tick_on = 1'b1;
    int         nvec = 0;
    int         nbad = 0;
    int         tcnt = 0;

    always #5 clk = ~clk;

    sertx_top #(.FIFO_DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_data(wr_data), .word_len(word_len), .two_stop(two_stop),
        .par_sel(par_sel), .nine_bit(nine_bit), .brk(brk), .txd(txd),
        .fifo_empty(fifo_empty), .tx_idle(tx_idle)
    );

    // Strobe every fourth clock, changed just after the edge
    initial forever begin
        @(posedge clk);
        #1;
        tcnt = (tcnt + 1) % 4;
        bit_tick = tick_on && (tcnt == 0);
    end

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    function automatic int ndata(input logic nb, input logic [1:0] wl);
        return nb ? 9 : 5 + int'(wl);
    endfunction

    function automatic int nbits(input logic nb, input logic [1:0] wl, input logic ts, input logic [2:0] ps);
        return 1 + ndata(nb, wl) + ((!nb && ps[0]) ? 1 : 0) + (ts ? 2 : 1);
    endfunction

    function automatic logic exp_bit(input logic [8:0] d, input logic nb, input logic [1:0] wl,
                                     input logic [2:0] ps, input int idx);
        int nd = ndata(nb, wl);
        int ones = 0;
        if (idx == 0) return 1'b0;
        if (idx <= nd) return d[idx - 1];
        if (!nb && ps[0] && idx == nd + 1) begin
            for (int i = 0; i < nd; i++) ones += int'(d[i]);
            case (ps[2:1])
                2'b00:   return (ones % 2) == 0;
                2'b01:   return (ones % 2) == 1;
                2'b10:   return 1'b1;
                default: return 1'b0;
            endcase
        end
        return 1'b1;
    endfunction

    task automatic put(input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        @(negedge clk);
        while (!bit_tick) @(negedge clk);
        b = txd;
    endtask

    // Receive one frame; strict demands a start bit on the very next strobe
    task automatic recv(input logic [8:0] d, input bit strict, input bit last,
                        input int bk_from, input int bk_to);
        logic  b;
        int    nd = ndata(nine_bit, word_len);
        int    tot = nbits(nine_bit, word_len, two_stop, par_sel);
        int    tries = 0;
        string r;
        get_bit(b);
        if (strict) chk(b, 1'b0, "R11", "back-to-back start bit");
        else begin
            while (b !== 1'b0 && tries < 3) begin
                get_bit(b);
                tries++;
            end
            chk(b, 1'b0, "R11", "start bit after write");
        end
        if (last) chk(fifo_empty, 1'b1, "R9", "empty after last take");
        for (int idx = 1; idx < tot; idx++) begin
            if (idx == bk_from) brk = 1'b1;
            get_bit(b);
            if (idx >= bk_from && idx <= bk_to) begin
                chk(b, 1'b0, "R8", "line low during break");
                if (idx == bk_to) brk = 1'b0;
                continue;
            end
            if (idx <= nd) r = nine_bit ? "R6" : "R2";
            else if (idx == nd + 1 && !nine_bit && par_sel[0]) r = par_sel[2] ? "R5" : "R4";
            else if (idx == nd + 1) r = nine_bit ? "R6" : "R3";
            else r = "R7";
            chk(b, exp_bit(d, nine_bit, word_len, par_sel, idx), r, $sformatf("bit %0d", idx));
        end
        if (last) begin
            chk(tx_idle, 1'b0, "R10", "busy during last stop bit");
            @(posedge clk);
            @(negedge clk);
            chk(tx_idle, 1'b1, "R10", "idle after last stop bit");
        end
    endtask

    initial begin
        logic b;
        logic [8:0] d;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(txd, 1'b1, "R1", "txd in reset");
        chk(fifo_empty, 1'b1, "R1", "empty in reset");
        chk(tx_idle, 1'b1, "R1", "idle in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd, 1'b1, "R1", "txd after reset");

        // Sweep all formats: R2 R3 R4 R5 R6 R7 R9 R10
        for (int nb = 0; nb < 2; nb++)
            for (int wl = 0; wl < 4; wl++)
                for (int ps = 0; ps < 8; ps++)
                    for (int ts = 0; ts < 2; ts++)
                        for (int k = 0; k < 2; k++) begin
                            @(negedge clk);
                            nine_bit = nb[0];
                            word_len = wl[1:0];
                            par_sel  = ps[2:0];
                            two_stop = ts[0];
                            d = 9'((wl * 73 + ps * 29 + ts * 13 + k * 151 + nb * 7 + 5) & 511);
                            put(d);
                            chk(fifo_empty, 1'b0, "R9", "not empty after write");
                            recv(d, 1'b0, 1'b1, 99, 0);
                        end

        // R11 back-to-back frames
        nine_bit = 1'b0; word_len = 2'b11; par_sel = 3'b011; two_stop = 1'b0;
        put(9'h0C3); put(9'h05A); put(9'h0FF);
        recv(9'h0C3, 1'b0, 1'b0, 99, 0);
        recv(9'h05A, 1'b1, 1'b0, 99, 0);
        recv(9'h0FF, 1'b1, 1'b1, 99, 0);

        // R12 writes beyond depth dropped
        tick_on = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 6; i++) put(9'(8'h11 * (i + 1)));
        chk(fifo_empty, 1'b0, "R12", "queue filled");
        tick_on = 1'b1;
        recv(9'h011, 1'b0, 1'b0, 99, 0);
        recv(9'h022, 1'b1, 1'b0, 99, 0);
        recv(9'h033, 1'b1, 1'b0, 99, 0);
        recv(9'h044, 1'b1, 1'b1, 99, 0);
        for (int i = 0; i < 4; i++) begin
            get_bit(b);
            chk(b, 1'b1, "R12", "no frame for dropped writes");
        end
        chk(tx_idle, 1'b1, "R12", "idle after dropped writes");

        // R8 break while idle and in mid-frame
        @(negedge clk);
        brk = 1'b1;
        @(negedge clk);
        chk(txd, 1'b0, "R8", "break while idle");
        brk = 1'b0;
        @(negedge clk);
        chk(txd, 1'b1, "R8", "line high after break");
        word_len = 2'b11; par_sel = 3'b001; two_stop = 1'b1;
        put(9'h0A5);
        recv(9'h0A5, 1'b0, 1'b1, 3, 6);

        finish_run();
    end
endmodule